// File: doc/BRIEF.md
# Input-Inversion Variant Scorer for a 4-Input Look-Up Table

The block takes the truth table of a four-input look-up table and rates every way its inputs could be fed in inverted form. Inverting any input and reordering the stored bits to match leaves the computed function unchanged. The resulting physical tables differ, however, in how well they hide a short between two neighbouring input lines. For each of the sixteen inversion variants the block injects the three neighbouring-line shorts. It counts the stored bits that would then be read wrongly and forms a risk score from an optional per-bit weight table. It also tracks which variant scores best.

A run begins when `start` is seen while the block is idle. The table, the weights and the weighting mode are captured at that moment. One variant is scored per clock and streamed out with its index. After the sixteenth variant, `done` pulses once. At that point the best variant's index is valid, together with the risk of the unmodified variant and the minimum and maximum risk over all variants. These result registers hold until the next run completes its first variant.

The controller has three named states. IDLE waits for `start`. SCAN steps the variant counter from 0 to 15. FINISH is the single cycle that raises `done`. The transitions are:
- IDLE→SCAN on `start`.
- SCAN→SCAN while the counter is below 15.
- SCAN→FINISH at counter 15.
- FINISH→IDLE always.

Top module: `lut_flip_scorer`

## Requirements
- R1: After reset, `busy`, `ver_valid` and `done` are 0.
- R2: A `start` accepted in IDLE makes `ver_valid` high for exactly 16 consecutive cycles, beginning the cycle after the accepting edge, with `ver_idx` counting 0,1,…,15. `done` is high for exactly the single following cycle. `busy` is high from the first `ver_valid` cycle through the `done` cycle.
- R3: The table is addressed by x = {D,C,B,A}, with A at bit 0 and D at bit 3 (D,C pick the row and B,A the column). Bit k of the variant index inverts input k. The variant table holds V[x] = T[x XOR index], so index 0 is the unmodified table and index 15 inverts all four inputs.
- R4: The shorts are modelled on three input pairs: A–B (bits 0,1), B–C (bits 1,2) and C–D (bits 2,3). A short makes an address whose two shorted bits differ read V at the same address with both bits set to 1. A bit is counted as erroneous when that readout differs from V[x]. `ver_err_ab`, `ver_err_bc` and `ver_err_cd` report these counts for the three pairs, each from 0 to 8.
- R5: `ver_err_total` equals the sum of the three per-pair counts.
- R6: With weighting on, `ver_risk` is the sum over the three shorts of the weights of the erroneous addresses x. The weight of address x is `weights_in[8x+7:8x]`, an unsigned 8-bit value captured at start.
- R7: With weighting off (`use_weights`=0 at start), every weight is 1, so `ver_risk` equals `ver_err_total`.
- R8: When `done` is high, `risk_min` and `risk_max` are the minimum and maximum risk over the 16 variants, and `risk_cur` is the risk of variant 0. `best_idx` is the lowest index whose risk equals `risk_min`.
- R9: Inputs are captured only by a `start` seen in IDLE. A `start`, or a change to `lut_in`, `weights_in` or `use_weights`, during SCAN or FINISH has no effect on the run's outputs.
- R10: For the function (A AND B) XOR (C AND D), variant 0 gives counts 8, 4 and 8 for A–B, B–C and C–D, a total of 20. Variant 15 gives 0, 4 and 0, a total of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only in IDLE) |
| lut_in | input | 16 | Truth table, bit x = output at address {D,C,B,A} |
| use_weights | input | 1 | 1: use `weights_in`; 0: all weights are 1 |
| weights_in | input | 128 | Sixteen 8-bit weights, weight of address x at bits 8x+7:8x |
| busy | output | 1 | Run in progress (SCAN or FINISH) |
| ver_valid | output | 1 | Variant result on the ver_* outputs is valid |
| ver_idx | output | 4 | Index of the variant being reported |
| ver_err_ab | output | 4 | Erroneous bits under the A–B short |
| ver_err_bc | output | 4 | Erroneous bits under the B–C short |
| ver_err_cd | output | 4 | Erroneous bits under the C–D short |
| ver_err_total | output | 5 | Sum of the three counts |
| ver_risk | output | 13 | Weighted risk of the variant |
| done | output | 1 | One-cycle pulse: run results valid |
| best_idx | output | 4 | Lowest-index variant with minimum risk |
| risk_cur | output | 13 | Risk of variant 0 |
| risk_min | output | 13 | Minimum risk over all variants |
| risk_max | output | 13 | Maximum risk over all variants |

## Verification
The known XOR-of-ANDs function pins down the short model and the address ordering, because its direct and fully inverted variants have fixed, asymmetric error counts. The all-zero and all-one tables give zero errors for every variant, which separates strict-less-than ranking from other tie rules. Random tables with random weights exercise the mapping of weight bytes to addresses and the min/max tracking. Random tables with weighting off show that the risk collapses to the error count. In further runs, a second `start` and a new `lut_in` are applied mid-scan to show that the captured inputs alone decide the results.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    localparam int LFS_NIN = 4;
    localparam int LFS_ENT = 1 << LFS_NIN;
    localparam int LFS_NSH = LFS_NIN - 1;
    localparam int LFS_WW  = 8;
    localparam int LFS_CW  = $clog2(LFS_ENT / 2 + 1);
    localparam int LFS_TW  = $clog2(LFS_NSH * (LFS_ENT / 2) + 1);
    localparam int LFS_RW  = 13;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } lfs_state_e;
endpackage

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
    import lfs_pkg::*;
#(
    parameter int NIN = LFS_NIN,
    parameter int WW  = LFS_WW,
    localparam int ENT = 1 << NIN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ENT-1:0]      lut_in,
    input  logic                use_weights,
    input  logic [ENT*WW-1:0]   weights_in,
    output logic [ENT-1:0]      table_q,
    output logic [ENT*WW-1:0]   wt_q,
    output logic                unit_q,
    output logic [NIN-1:0]      idx,
    output logic                scan,
    output logic                first,
    output logic                fin,
    output logic                busy
);
    localparam logic [NIN-1:0] IDX_LAST = '1;

    lfs_state_e state, state_n;
    logic [ENT*WW-1:0] wt_sel;
    logic              accept;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start) state_n = ST_SCAN;
            ST_SCAN:   if (idx == IDX_LAST) state_n = ST_FINISH;
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Outputs from state
    always_comb begin
        scan   = 1'b0;
        fin    = 1'b0;
        busy   = 1'b0;
        accept = 1'b0;
        unique case (state)
            ST_IDLE:   accept = start;
            ST_SCAN:   begin scan = 1'b1; busy = 1'b1; end
            ST_FINISH: begin fin = 1'b1; busy = 1'b1; end
            default:   ;
        endcase
    end

    assign first = scan && (idx == '0);

    // Weight selection: unit weights when weighting is off
    for (genvar e = 0; e < ENT; e++) begin : g_wsel
        assign wt_sel[e*WW +: WW] = use_weights ? weights_in[e*WW +: WW] : WW'(1);
    end

    // Capture and variant counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            table_q <= '0;
            wt_q    <= '0;
            unit_q  <= 1'b0;
            idx     <= '0;
        end else if (accept) begin
            table_q <= lut_in;
            wt_q    <= wt_sel;
            unit_q  <= ~use_weights;
            idx     <= '0;
        end else if (scan) begin
            idx <= idx + 1'b1;
        end
    end

    assert_scan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && idx != IDX_LAST) |=> (scan && idx == $past(idx) + 1'b1));
    assert_scan_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && idx == IDX_LAST) |=> fin);
    assert_fin_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (!fin && !busy));
    assert_hold_inputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(table_q) && $stable(wt_q) && $stable(unit_q)));
endmodule

// File: rtl/lfs_version_eval.sv
module lfs_version_eval
    import lfs_pkg::*;
#(
    parameter int NIN = LFS_NIN,
    parameter int WW  = LFS_WW,
    parameter int RW  = LFS_RW,
    localparam int ENT = 1 << NIN,
    localparam int NSH = NIN - 1,
    localparam int CW  = $clog2(ENT / 2 + 1),
    localparam int TW  = $clog2(NSH * (ENT / 2) + 1)
) (
    input  logic [ENT-1:0]    table_q,
    input  logic [ENT*WW-1:0] wt_q,
    input  logic [NIN-1:0]    mask,
    output logic [CW-1:0]     err_cnt [NSH],
    output logic [TW-1:0]     err_tot,
    output logic [RW-1:0]     risk
);
    logic [ENT-1:0] vt;
    logic [ENT-1:0] err [NSH];

    // Variant table: reordered by XOR of the address with the mask
    always_comb begin
        for (int x = 0; x < ENT; x++) begin
            vt[x] = table_q[NIN'(x) ^ mask];
        end
    end

    // Short injection: mismatched pair reads as both-set address
    for (genvar s = 0; s < NSH; s++) begin : g_short
        for (genvar x = 0; x < ENT; x++) begin : g_addr
            localparam int  PARTNER = x | (3 << s);
            localparam bit  SPLIT   = (((x >> s) & 1) != ((x >> (s + 1)) & 1));
            if (SPLIT) begin : g_cmp
                assign err[s][x] = vt[x] ^ vt[PARTNER];
            end else begin : g_zero
                assign err[s][x] = 1'b0;
            end
        end
    end

    // Per-short counts and total
    always_comb begin
        err_tot = '0;
        for (int s = 0; s < NSH; s++) begin
            err_cnt[s] = '0;
            for (int x = 0; x < ENT; x++) begin
                err_cnt[s] = err_cnt[s] + CW'(err[s][x]);
            end
            err_tot = err_tot + TW'(err_cnt[s]);
        end
    end

    // Weighted risk over all shorts
    always_comb begin
        risk = '0;
        for (int s = 0; s < NSH; s++) begin
            for (int x = 0; x < ENT; x++) begin
                if (err[s][x]) risk = risk + RW'(wt_q[x*WW +: WW]);
            end
        end
    end
endmodule

// File: rtl/lfs_rank.sv
module lfs_rank
    import lfs_pkg::*;
#(
    parameter int NIN = LFS_NIN,
    parameter int RW  = LFS_RW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid,
    input  logic           first,
    input  logic [NIN-1:0] idx,
    input  logic [RW-1:0]  risk,
    output logic [NIN-1:0] best_idx,
    output logic [RW-1:0]  r_cur,
    output logic [RW-1:0]  r_min,
    output logic [RW-1:0]  r_max
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_idx <= '0;
            r_cur    <= '0;
            r_min    <= '0;
            r_max    <= '0;
        end else if (valid && first) begin
            best_idx <= idx;
            r_cur    <= risk;
            r_min    <= risk;
            r_max    <= risk;
        end else if (valid) begin
            if (risk < r_min) begin
                r_min    <= risk;
                best_idx <= idx;
            end
            if (risk > r_max) r_max <= risk;
        end
    end

    assert_tie_keeps_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !first && risk >= r_min) |=> $stable(best_idx));
    assert_min_improves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !first && risk < r_min) |=> (best_idx == $past(idx)));
endmodule

// File: rtl/lut_flip_scorer.sv
module lut_flip_scorer
    import lfs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [LFS_ENT-1:0]       lut_in,
    input  logic                     use_weights,
    input  logic [LFS_ENT*LFS_WW-1:0] weights_in,
    output logic                     busy,
    output logic                     ver_valid,
    output logic [LFS_NIN-1:0]       ver_idx,
    output logic [LFS_CW-1:0]        ver_err_ab,
    output logic [LFS_CW-1:0]        ver_err_bc,
    output logic [LFS_CW-1:0]        ver_err_cd,
    output logic [LFS_TW-1:0]        ver_err_total,
    output logic [LFS_RW-1:0]        ver_risk,
    output logic                     done,
    output logic [LFS_NIN-1:0]       best_idx,
    output logic [LFS_RW-1:0]        risk_cur,
    output logic [LFS_RW-1:0]        risk_min,
    output logic [LFS_RW-1:0]        risk_max
);
    logic [LFS_ENT-1:0]        table_q;
    logic [LFS_ENT*LFS_WW-1:0] wt_q;
    logic                      unit_q;
    logic [LFS_NIN-1:0]        idx;
    logic                      scan, first, fin;
    logic [LFS_CW-1:0]         err_cnt [LFS_NSH];

    lfs_ctrl #(.NIN(LFS_NIN), .WW(LFS_WW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .lut_in(lut_in),
        .use_weights(use_weights), .weights_in(weights_in),
        .table_q(table_q), .wt_q(wt_q), .unit_q(unit_q), .idx(idx),
        .scan(scan), .first(first), .fin(fin), .busy(busy)
    );

    lfs_version_eval #(.NIN(LFS_NIN), .WW(LFS_WW), .RW(LFS_RW)) u_eval (
        .table_q(table_q), .wt_q(wt_q), .mask(idx),
        .err_cnt(err_cnt), .err_tot(ver_err_total), .risk(ver_risk)
    );

    lfs_rank #(.NIN(LFS_NIN), .RW(LFS_RW)) u_rank (
        .clk(clk), .rst_n(rst_n), .valid(scan), .first(first), .idx(idx),
        .risk(ver_risk), .best_idx(best_idx), .r_cur(risk_cur),
        .r_min(risk_min), .r_max(risk_max)
    );

    assign ver_valid  = scan;
    assign ver_idx    = idx;
    assign ver_err_ab = err_cnt[0];
    assign ver_err_bc = err_cnt[1];
    assign ver_err_cd = err_cnt[2];
    assign done       = fin;

    assert_unit_risk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ver_valid && unit_q) |-> (ver_risk == LFS_RW'(ver_err_total)));
    assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (risk_min <= risk_cur && risk_cur <= risk_max));
    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && ver_valid));
endmodule

// File: tb/lut_flip_scorer_bench.sv
module lut_flip_scorer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  lut_in = '0;
    logic         use_weights = 1'b0;
    logic [127:0] weights_in = '0;
    logic         busy, ver_valid, done;
    logic [3:0]   ver_idx, ver_err_ab, ver_err_bc, ver_err_cd, best_idx;
    logic [4:0]   ver_err_total;
    logic [12:0]  ver_risk, risk_cur, risk_min, risk_max;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lut_flip_scorer u_lut_flip_scorer (
        .clk(clk), .rst_n(rst_n), .start(start), .lut_in(lut_in),
        .use_weights(use_weights), .weights_in(weights_in), .busy(busy),
        .ver_valid(ver_valid), .ver_idx(ver_idx), .ver_err_ab(ver_err_ab),
        .ver_err_bc(ver_err_bc), .ver_err_cd(ver_err_cd),
        .ver_err_total(ver_err_total), .ver_risk(ver_risk), .done(done),
        .best_idx(best_idx), .risk_cur(risk_cur), .risk_min(risk_min),
        .risk_max(risk_max)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Error count of short s for variant m (pair reads as both bits set)
    function automatic int ref_err(input logic [15:0] t, input int m, input int s);
        int n = 0;
        for (int x = 0; x < 16; x++) begin
            if (((x >> s) & 1) != ((x >> (s + 1)) & 1)) begin
                if (t[x ^ m] != t[(x | (3 << s)) ^ m]) n++;
            end
        end
        return n;
    endfunction

    function automatic int ref_risk(input logic [15:0] t, input logic [127:0] w,
                                    input bit uw, input int m);
        int r = 0;
        for (int s = 0; s < 3; s++) begin
            for (int x = 0; x < 16; x++) begin
                if (((x >> s) & 1) != ((x >> (s + 1)) & 1) &&
                    t[x ^ m] != t[(x | (3 << s)) ^ m])
                    r += uw ? int'(w[x*8 +: 8]) : 1;
            end
        end
        return r;
    endfunction

    // One full run; disturb applies a mid-scan start and new inputs (R9)
    task automatic run(input logic [15:0] t, input logic [127:0] w, input bit uw,
                       input bit disturb);
        int rk [16];
        int bmin, bmax, bidx;
        for (int m = 0; m < 16; m++) rk[m] = ref_risk(t, w, uw, m);
        bmin = rk[0]; bmax = rk[0]; bidx = 0;
        for (int m = 1; m < 16; m++) begin
            if (rk[m] < bmin) begin bmin = rk[m]; bidx = m; end
            if (rk[m] > bmax) bmax = rk[m];
        end
        @(negedge clk);
        lut_in = t; weights_in = w; use_weights = uw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int v = 0; v < 16; v++) begin
            if (disturb && v == 5) begin
                start = 1'b1; lut_in = ~t; weights_in = ~w; use_weights = ~uw;
            end
            if (disturb && v == 7) start = 1'b0;
            chk(ver_valid === 1'b1, "R2 ver_valid", int'(ver_valid), 1);
            chk(ver_idx == 4'(v), "R2 ver_idx", int'(ver_idx), v);
            chk(busy === 1'b1, "R2 busy", int'(busy), 1);
            chk(int'(ver_err_ab) == ref_err(t, v, 0), "R4 A-B count", int'(ver_err_ab), ref_err(t, v, 0));
            chk(int'(ver_err_bc) == ref_err(t, v, 1), "R4 B-C count", int'(ver_err_bc), ref_err(t, v, 1));
            chk(int'(ver_err_cd) == ref_err(t, v, 2), "R4 C-D count", int'(ver_err_cd), ref_err(t, v, 2));
            chk(int'(ver_err_total) == ref_err(t, v, 0) + ref_err(t, v, 1) + ref_err(t, v, 2),
                "R5 total", int'(ver_err_total),
                ref_err(t, v, 0) + ref_err(t, v, 1) + ref_err(t, v, 2));
            chk(int'(ver_risk) == rk[v], uw ? "R6 risk" : "R7 unit risk", int'(ver_risk), rk[v]);
            if (disturb) chk(int'(ver_risk) == rk[v], "R9 mid-run inputs ignored", int'(ver_risk), rk[v]);
            @(negedge clk);
        end
        chk(done === 1'b1, "R2 done", int'(done), 1);
        chk(ver_valid === 1'b0, "R2 valid ends", int'(ver_valid), 0);
        chk(int'(best_idx) == bidx, "R8 best_idx", int'(best_idx), bidx);
        chk(int'(risk_min) == bmin, "R8 risk_min", int'(risk_min), bmin);
        chk(int'(risk_max) == bmax, "R8 risk_max", int'(risk_max), bmax);
        chk(int'(risk_cur) == rk[0], "R8 risk_cur", int'(risk_cur), rk[0]);
        @(negedge clk);
        chk(done === 1'b0, "R2 done single cycle", int'(done), 0);
        chk(busy === 1'b0, "R2 busy ends", int'(busy), 0);
        chk(ver_valid === 1'b0, "R9 no restart", int'(ver_valid), 0);
    endtask

    initial begin
        logic [15:0]  t;
        logic [127:0] w;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(ver_valid === 1'b0, "R1 ver_valid", int'(ver_valid), 0);
        chk(done === 1'b0, "R1 done", int'(done), 0);
        rst_n = 1'b1;

        // R10 / R3 known function: (A AND B) XOR (C AND D)
        t = '0;
        for (int x = 0; x < 16; x++) t[x] = (x[0] & x[1]) ^ (x[2] & x[3]);
        @(negedge clk);
        lut_in = t; use_weights = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int v = 0; v < 16; v++) begin
            if (v == 0) begin
                chk(ver_err_ab == 4'd8, "R10 direct A-B", int'(ver_err_ab), 8);
                chk(ver_err_bc == 4'd4, "R10 direct B-C", int'(ver_err_bc), 4);
                chk(ver_err_cd == 4'd8, "R10 direct C-D", int'(ver_err_cd), 8);
                chk(ver_err_total == 5'd20, "R10 direct total", int'(ver_err_total), 20);
            end
            if (v == 15) begin
                chk(ver_err_ab == 4'd0, "R10 inverted A-B", int'(ver_err_ab), 0);
                chk(ver_err_bc == 4'd4, "R10 inverted B-C", int'(ver_err_bc), 4);
                chk(ver_err_cd == 4'd0, "R10 inverted C-D", int'(ver_err_cd), 0);
                chk(ver_err_total == 5'd4, "R10 inverted total", int'(ver_err_total), 4);
            end
            @(negedge clk);
        end
        @(negedge clk);

        run(t, '0, 1'b0, 1'b0);                  // R3 full compare of known function
        run(16'h0000, '1, 1'b1, 1'b0);           // R8 all ties at zero
        run(16'hFFFF, '1, 1'b1, 1'b0);           // R8 all ties at zero
        run(16'h0001, {16{8'hFF}}, 1'b1, 1'b0);  // R6 full-scale weights
        for (int k = 0; k < 10; k++) begin
            t = 16'($urandom);
            for (int e = 0; e < 4; e++) w[e*32 +: 32] = $urandom;
            run(t, w, k[0], (k % 3) == 2);       // R6/R7 random, R9 disturbed
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule